// File: doc/BRIEF.md
# Sixteen-bit compare timer with output pin action

The block is a 16-bit up-counter that advances once for each cycle in which its tick enable is high. The tick normally comes from a prescaler elsewhere on the chip. A 4-bit wave mode input picks how the counter wraps. In free-running mode it wraps at all-ones. In the two clear-on-compare modes it returns to zero after reaching a top value. That top value comes either from compare register A or from a separate top register.

A compare-A match drives one output pin through an action unit. The action, set by a 2-bit code, can do nothing, toggle the pin, drive it low or drive it high. The same action can be fired at any time by a force strobe.

Three sticky flags record events:
- overflow of the counter;
- a compare-A match;
- reaching the top register in the top-register mode.

Each flag is cleared by its own write-one input. The counter, the compare register and the top register can each be written by the host at any time.

Top module: `cmp_timer16`

## Requirements
- R1: After reset, `count`, all three flags and `out_pin` are 0, and the compare and top registers hold 0.
- R2: In free-running mode (wave mode 0, and every value other than 4 and 12), each tick adds one to `count`, and all-ones wraps to 0. With neither a tick nor a host write, `count` holds.
- R3: `ovf_flag` reads 1 in the same cycle in which `count` first reads 0 after wrapping from all-ones. Hardware never clears it.
- R4: When `cnt_wr` is high, `count` takes `cnt_wdata` in the next cycle, whatever the tick does. That cycle produces no match, flag or pin event.
- R5: With wave mode 4, the counter counts 0, 1, … up to the compare-A value, then 0 again, so one period is compare-A plus one ticks. `cmpa_flag` is set by the tick that leaves the top value.
- R6: With wave mode 12, the top value comes from the top register, and `cap_flag` is set by the tick that leaves the top value. `cap_flag` is never set in any other mode.
- R7: In every mode, a tick that sees `count` equal to compare A (with no host write) sets `cmpa_flag`.
- R8: A compare-A match applies the action code on `out_mode`, and `out_pin` shows the result one cycle later. The codes are: 00 leaves the pin alone, 01 inverts it, 10 drives it to 0, and 11 drives it to 1.
- R9: A change of `out_mode` alone never moves `out_pin`. The new code is first used at the next match or force.
- R10: A `force_cmp` pulse applies the current action code in the next cycle. It does not set `cmpa_flag` and does not alter `count`. A force in the same cycle as a match performs the action once.
- R11: Each flag clears in the cycle after a 1 on its clear input. A set in the same cycle as a clear wins, so the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable from the timer-clock divider |
| wave_mode | input | 4 | Wrap mode: 4 = top from compare A, 12 = top from top register, others = free running |
| out_mode | input | 2 | Pin action code used on match or force |
| force_cmp | input | 1 | Force strobe: apply the pin action now |
| cnt_wr | input | 1 | Host write strobe for the counter |
| cnt_wdata | input | 16 | Counter write value |
| cmpa_wr | input | 1 | Host write strobe for compare A |
| cmpa_wdata | input | 16 | Compare A write value |
| top_wr | input | 1 | Host write strobe for the top register |
| top_wdata | input | 16 | Top register write value |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| cmpa_clr | input | 1 | Write-one clear of the compare-A flag |
| cap_clr | input | 1 | Write-one clear of the top-reached flag |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| cmpa_flag | output | 1 | Compare-A match flag |
| cap_flag | output | 1 | Top-register reached flag |
| out_pin | output | 1 | Compare output pin |

## Verification
The properties assume that reset is held high through the first clock edge. They also assume that a match counts only when `tick` is high and `cnt_wr` is low, so a host write in the same cycle as a tick is treated as a write and never as a match. The stimulus changes every input only between edges. It pulses `force_cmp`, the write strobes and the clear inputs for a single cycle. Counter preloads are issued with `tick` low, except in the one check that deliberately collides a write with a matching tick.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
  typedef enum logic [1:0] {
    SEL_FREE = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_TOP  = 2'd2
  } wrap_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  localparam logic [3:0] WM_CTC_CMP = 4'd4;
  localparam logic [3:0] WM_CTC_TOP = 4'd12;

  function automatic wrap_sel_e decode_wave(input logic [3:0] m);
    case (m)
      WM_CTC_CMP: decode_wave = SEL_CMP;
      WM_CTC_TOP: decode_wave = SEL_TOP;
      default:    decode_wave = SEL_FREE;
    endcase
  endfunction
endpackage

// File: rtl/tmr16_counter.sv
`timescale 1ns/1ps
module tmr16_counter
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  wrap_sel_e    sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         ev_cmp,
  output logic         ev_top,
  output logic         ev_ovf
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic live;
  logic at_top;

  // A host write in this cycle masks every event.
  assign live   = tick && !wr;
  assign ev_cmp = live && (cnt == cmp_val);
  assign ev_top = live && (sel == SEL_TOP) && (cnt == top_val);
  assign ev_ovf = live && (cnt == CNT_MAX);

  always_comb begin
    case (sel)
      SEL_CMP: at_top = (cnt == cmp_val);
      SEL_TOP: at_top = (cnt == top_val);
      default: at_top = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (wr)       cnt <= wdata;
    else if (tick) begin
      if (at_top)      cnt <= '0;
      else             cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/tmr16_flags.sv
`timescale 1ns/1ps
module tmr16_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr16_outunit.sv
`timescale 1ns/1ps
module tmr16_outunit
  import tmr16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       match,
  input  logic       force_s,
  input  logic [1:0] act,
  output logic       pin
);
  logic fire;
  logic nxt;

  assign fire = match || force_s;

  always_comb begin
    case (pin_act_e'(act))
      ACT_TOGGLE: nxt = ~pin;
      ACT_LOW:    nxt = 1'b0;
      ACT_HIGH:   nxt = 1'b1;
      default:    nxt = pin;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pin <= 1'b0;
    else if (fire) pin <= nxt;
  end
endmodule

// File: rtl/cmp_timer16.sv
`timescale 1ns/1ps
module cmp_timer16
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [3:0]   wave_mode,
  input  logic [1:0]   out_mode,
  input  logic         force_cmp,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmpa_wr,
  input  logic [W-1:0] cmpa_wdata,
  input  logic         top_wr,
  input  logic [W-1:0] top_wdata,
  input  logic         ovf_clr,
  input  logic         cmpa_clr,
  input  logic         cap_clr,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         cmpa_flag,
  output logic         cap_flag,
  output logic         out_pin
);
  localparam int NFLAG = 3;

  logic [W-1:0] cmp_q;
  logic [W-1:0] top_q;
  wrap_sel_e    sel;
  logic         ev_cmp, ev_top, ev_ovf;
  logic [NFLAG-1:0] fset, fclr, fq;

  assign sel = decode_wave(wave_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      top_q <= '0;
    end else begin
      if (cmpa_wr) cmp_q <= cmpa_wdata;
      if (top_wr)  top_q <= top_wdata;
    end
  end

  tmr16_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .sel(sel),
    .wr(cnt_wr), .wdata(cnt_wdata),
    .cmp_val(cmp_q), .top_val(top_q),
    .cnt(count), .ev_cmp(ev_cmp), .ev_top(ev_top), .ev_ovf(ev_ovf)
  );

  assign fset = {ev_top, ev_cmp, ev_ovf};
  assign fclr = {cap_clr, cmpa_clr, ovf_clr};

  tmr16_flags #(.N(NFLAG)) u_flg (
    .clk(clk), .rst(rst), .set(fset), .clr(fclr), .flag(fq)
  );

  assign ovf_flag  = fq[0];
  assign cmpa_flag = fq[1];
  assign cap_flag  = fq[2];

  tmr16_outunit u_out (
    .clk(clk), .rst(rst), .match(ev_cmp), .force_s(force_cmp),
    .act(out_mode), .pin(out_pin)
  );
endmodule

// File: rtl/tmr16_chk.sv
`timescale 1ns/1ps
module tmr16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_wdata,
  input logic [3:0]   wave_mode,
  input logic         force_cmp,
  input logic         ovf_clr,
  input logic         cmpa_flag,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_q,
  input logic         ovf_flag,
  input logic         out_pin
);
  logic hit_a;
  assign hit_a = tick && !cnt_wr && (count == cmp_q);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && count == '1 && wave_mode != 4'd4 && wave_mode != 4'd12) |=> (count == '0));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(count));
  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && count == '1) |=> ovf_flag);
  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  assert_host_write_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(cnt_wdata)));
  assert_ctc_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wave_mode == 4'd4 && hit_a) |=> (count == '0));
  assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!hit_a && !force_cmp) |=> $stable(out_pin));
  assert_force_noflag_R10: assert property (@(posedge clk) disable iff (rst)
    (force_cmp && !hit_a && !cmpa_flag) |=> !cmpa_flag);
endmodule

bind cmp_timer16 tmr16_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .wave_mode(wave_mode), .force_cmp(force_cmp), .ovf_clr(ovf_clr),
  .cmpa_flag(cmpa_flag), .count(count), .cmp_q(cmp_q),
  .ovf_flag(ovf_flag), .out_pin(out_pin)
);

// File: tb/sim_cmp_timer16.sv
`timescale 1ns/1ps
module sim_cmp_timer16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [3:0]  wave_mode = 4'd0;
  logic [1:0]  out_mode = 2'b00;
  logic        force_cmp = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        cmpa_wr = 1'b0;
  logic [15:0] cmpa_wdata = '0;
  logic        top_wr = 1'b0;
  logic [15:0] top_wdata = '0;
  logic        ovf_clr = 1'b0, cmpa_clr = 1'b0, cap_clr = 1'b0;
  logic [15:0] count;
  logic        ovf_flag, cmpa_flag, cap_flag, out_pin;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_timer16 #(.W(16)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wave_mode(wave_mode), .out_mode(out_mode),
    .force_cmp(force_cmp), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata), .top_wr(top_wr), .top_wdata(top_wdata),
    .ovf_clr(ovf_clr), .cmpa_clr(cmpa_clr), .cap_clr(cap_clr),
    .count(count), .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cap_flag(cap_flag),
    .out_pin(out_pin)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_cnt(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; step(); cnt_wr = 1'b0;
  endtask

  task automatic load_cmp(input logic [15:0] v);
    cmpa_wr = 1'b1; cmpa_wdata = v; step(); cmpa_wr = 1'b0;
  endtask

  task automatic load_top(input logic [15:0] v);
    top_wr = 1'b1; top_wdata = v; step(); top_wr = 1'b0;
  endtask

  task automatic clr_all();
    ovf_clr = 1'b1; cmpa_clr = 1'b1; cap_clr = 1'b1; step();
    ovf_clr = 1'b0; cmpa_clr = 1'b0; cap_clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1; repeat (n) step(); tick = 1'b0;
  endtask

  task automatic pulse_force(input logic [1:0] code);
    out_mode = code; force_cmp = 1'b1; step(); force_cmp = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flags", {ovf_flag, cmpa_flag, cap_flag}, 0);
    chk("R1 pin", out_pin, 0);
    ticks(1);
    chk("R1 cmp reg zero -> match at 0", cmpa_flag, 1);
    chk("R1 pin untouched code 00", out_pin, 0);
    clr_all();
    chk("R11 clear all", {ovf_flag, cmpa_flag, cap_flag}, 0);

    // R2 sweep all wave modes: cmp=top=2, 5 ticks from 0
    load_cmp(16'd2); load_top(16'd2);
    for (int m = 0; m < 16; m++) begin
      wave_mode = 4'(m);
      load_cnt(16'd0);
      ticks(5);
      chk((m == 4 || m == 12) ? "R5/R6 mode sweep" : "R2 mode sweep", count,
          (m == 4 || m == 12) ? 32'd2 : 32'd5);
    end
    step(); step();
    chk("R2 hold without tick", count, (4'd15 == 4'd4) ? 2 : 5);

    // R2/R3 wrap and overflow flag
    wave_mode = 4'd0; load_cmp(16'h1000); clr_all();
    load_cnt(16'hFFFE);
    ticks(1);
    chk("R2 at max", count, 16'hFFFF);
    chk("R3 no ovf yet", ovf_flag, 0);
    ticks(1);
    chk("R2 wrap to zero", count, 0);
    chk("R3 ovf with zero", ovf_flag, 1);
    ticks(3);
    chk("R3 ovf sticky", ovf_flag, 1);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk("R11 ovf cleared", ovf_flag, 0);
    load_cnt(16'hFFFF);
    tick = 1'b1; ovf_clr = 1'b1; step(); tick = 1'b0; ovf_clr = 1'b0;
    chk("R11 set wins over clear", ovf_flag, 1);
    clr_all();

    // R5 CTC from compare A, toggle pin, sweep tops 1..6
    wave_mode = 4'd4; out_mode = 2'b01;
    for (int t = 1; t <= 6; t++) begin
      logic p0;
      int nm;
      bit ok_cnt;
      bit ok_flag;
      load_cmp(16'(t)); load_cnt(16'd0); clr_all();
      p0 = out_pin; nm = 0; ok_cnt = 1; ok_flag = 1;
      for (int i = 0; i < 3 * (t + 1); i++) begin
        ticks(1);
        if ((i % (t + 1)) == t) nm++;
        if (count !== 16'((i + 1) % (t + 1))) ok_cnt = 0;
        if (cmpa_flag !== (nm > 0)) ok_flag = 0;
      end
      chk("R5 ctc count sequence", ok_cnt, 1);
      chk("R5 cmpa flag at top", ok_flag, 1);
      chk("R8 toggle per match", out_pin, p0 ^ nm[0]);
      chk("R6 cap flag idle in mode 4", cap_flag, 0);
    end

    // R6 CTC from top register, no pin action
    wave_mode = 4'd12; out_mode = 2'b00; load_cmp(16'h0100);
    for (int t = 2; t <= 5; t++) begin
      bit ok_cnt;
      bit ok_flag;
      bit seen;
      logic p0;
      load_top(16'(t)); load_cnt(16'd0); clr_all();
      ok_cnt = 1; ok_flag = 1; seen = 0; p0 = out_pin;
      for (int i = 0; i < 2 * (t + 1); i++) begin
        ticks(1);
        if ((i % (t + 1)) == t) seen = 1;
        if (count !== 16'((i + 1) % (t + 1))) ok_cnt = 0;
        if (cap_flag !== seen) ok_flag = 0;
      end
      chk("R6 top-reg count sequence", ok_cnt, 1);
      chk("R6 cap flag at top", ok_flag, 1);
      chk("R7 no cmpa match below cmp", cmpa_flag, 0);
      chk("R8 code 00 no pin action", out_pin, p0);
    end

    // R7 compare match in free-running mode; R8 codes at match
    wave_mode = 4'd0; load_cmp(16'd7);
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        logic expp;
        pulse_force(s[0] ? 2'b11 : 2'b10);
        clr_all();
        out_mode = 2'(c);
        load_cnt(16'd6);
        ticks(1);
        chk("R7 no flag before match", cmpa_flag, 0);
        chk("R8 pin before match", out_pin, s[0]);
        ticks(1);
        case (c)
          0: expp = s[0];
          1: expp = ~s[0];
          2: expp = 1'b0;
          default: expp = 1'b1;
        endcase
        chk("R7 flag on match", cmpa_flag, 1);
        chk("R8 pin after match", out_pin, expp);
        chk("R7 free mode keeps counting", count, 8);
      end
    end

    // R9 code change alone does not move the pin
    pulse_force(2'b10);
    out_mode = 2'b11; step(); step(); step();
    chk("R9 pin unchanged on code write", out_pin, 0);
    load_cnt(16'd7); ticks(1);
    chk("R9 new code used at match", out_pin, 1);

    // R10 force: all codes from both pin states, no flag, counter kept
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        logic expp;
        pulse_force(s[0] ? 2'b11 : 2'b10);
        clr_all();
        load_cnt(16'd20);
        pulse_force(2'(c));
        case (c)
          0: expp = s[0];
          1: expp = ~s[0];
          2: expp = 1'b0;
          default: expp = 1'b1;
        endcase
        chk("R10 forced action", out_pin, expp);
        chk("R10 force leaves flag", cmpa_flag, 0);
        chk("R10 force leaves count", count, 20);
      end
    end
    // R10 force and match together toggle once
    pulse_force(2'b10); load_cnt(16'd7);
    out_mode = 2'b01; tick = 1'b1; force_cmp = 1'b1; step(); tick = 1'b0; force_cmp = 1'b0;
    chk("R10 single toggle on force+match", out_pin, 1);

    // R4 host write collides with a matching tick
    clr_all(); load_cnt(16'd7);
    out_mode = 2'b01;
    begin
      logic p0;
      p0 = out_pin;
      tick = 1'b1; cnt_wr = 1'b1; cnt_wdata = 16'h0123; step();
      tick = 1'b0; cnt_wr = 1'b0;
      chk("R4 write wins", count, 16'h0123);
      chk("R4 no flag on write", cmpa_flag, 0);
      chk("R4 no pin event on write", out_pin, p0);
    end

    // R11 cmpa and cap clears
    wave_mode = 4'd12; load_top(16'd1); load_cnt(16'd1); load_cmp(16'd1);
    ticks(1);
    chk("R11 both set", {cmpa_flag, cap_flag}, 2'b11);
    cmpa_clr = 1'b1; step(); cmpa_clr = 1'b0;
    chk("R11 cmpa clear only", {cmpa_flag, cap_flag}, 2'b01);
    cap_clr = 1'b1; step(); cap_clr = 1'b0;
    chk("R11 cap clear", cap_flag, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule